// File: doc/BRIEF.md
# Energy-Efficient Ethernet Low-Power-Idle Controller

This block decides when a MAC transmit path may drop into low-power idle and when it must come back out. The host programs two durations: a link-stable time, counted in millisecond ticks, and a wake time, counted in microsecond ticks. Once armed, the controller waits until the host-reported link has stayed up for the link-stable time. It then asserts the low-power request toward the PHY, provided the transmitter is idle and has nothing queued. While low-power idle is active, or while the PHY is waking, a hold output stalls transmit data. When a frame becomes pending, the controller drops the low-power request and keeps the hold asserted for the wake time. It then releases transmission.

The block also watches the PHY's receive low-power indication through a synchronizer chain. It records four events in sticky flags: transmit entry, transmit exit, receive entry and receive exit. Any flag that is set raises a maskable interrupt. Reading the control/status word clears all four flags.

Two register words are exposed, selected by a one-bit address. The control/status word is at address 0 and the timer word is at address 1. Writes take effect at the clock edge. Read data is combinational from the selected word.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset, `tx_lpi_o`, `tx_hold_o` and `irq_o` are 0, the control/status word reads 0, and the timer word reads the reset wake time in bits 15:0 and the reset link-stable time in bits 26:16.
- R2: The timer word holds the wake time (microsecond ticks) at bits 15:0 and the link-stable time (millisecond ticks) at bits 26:16; bits 31:27 read as 0.
- R3: Control bits in the control/status word: 16 = enable, 17 = automate, 18 = link up, 19 = interrupt mask. When enable or automate is set, the link-up bit is set, and at least L millisecond ticks have arrived since the link-up bit went to 1 (L = link-stable time), the controller enters low-power idle on the next clock edge. Entry raises `tx_lpi_o` and `tx_hold_o`. Status bit 8 reads 1 while in low-power idle.
- R4: Low-power idle is never entered while `tx_idle_i` is 0 or `tx_pend_i` is 1.
- R5: With automate set, a pending frame during low-power idle drops `tx_lpi_o` at the next edge. `tx_hold_o` stays high until W microsecond ticks have been counted (W = wake time) and falls on the edge after that.
- R6: With enable set and automate clear, a pending frame does not end low-power idle. Clearing both enable and automate ends it through the same wake wait as R5.
- R7: Clearing the link-up bit ends low-power idle or wake on the next edge with no wake wait, and restarts the link-stable count so that L new millisecond ticks are needed once the link returns.
- R8: Flag bit 0 is set on every transmit entry and flag bit 1 on every transmit exit.
- R9: Once it has passed the RX_SYNC-stage synchronizer, a rising edge of `rx_lpi_i` sets flag bit 2 and a falling edge sets flag bit 3. Status bit 9 shows the synchronized level.
- R10: A read of address 0 clears flags 3:0 at that edge. An event arriving in the same cycle as the read is kept. A read of address 1 clears nothing.
- R11: `irq_o` is 1 exactly when some flag is set and the interrupt mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (read side effects) |
| reg_addr_i | input | 1 | Word select: 0 control/status, 1 timer |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected word |
| tx_idle_i | input | 1 | MAC transmit path is idle |
| tx_pend_i | input | 1 | A transmit frame is waiting |
| rx_lpi_i | input | 1 | PHY reports receive low-power idle (asynchronous) |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| tx_lpi_o | output | 1 | Request low-power idle on the transmit line |
| tx_hold_o | output | 1 | Stall transmit data |
| irq_o | output | 1 | Low-power event interrupt |

## Verification
The bench builds the block with the full 16-bit wake and 11-bit link-stable fields, a three-stage receive synchronizer, and reset timer values of 5 and 2. Because both timers advance only on tick inputs that the bench drives, it can sweep every link-stable time from 0 to 3 against every wake time from 0 to 4 and predict the exact edge at which entry happens and the hold is released. The deeper synchronizer makes the receive-edge latency long enough that a status read can be placed on the very edge where a receive event lands, which exercises the set-over-clear case.

// File: rtl/eee_lpi_pkg.sv
`timescale 1ns/1ps
package eee_lpi_pkg;
   typedef enum logic [1:0] {
      LPI_ACTIVE = 2'd0,
      LPI_SLEEP  = 2'd1,
      LPI_WAKE   = 2'd2
   } lpi_state_e;

   localparam int REG_W      = 32;
   localparam int NUM_FLAGS  = 4;
   localparam int FLG_TX_IN  = 0;
   localparam int FLG_TX_OUT = 1;
   localparam int FLG_RX_IN  = 2;
   localparam int FLG_RX_OUT = 3;

   localparam int CS_TX_STATE = 8;
   localparam int CS_RX_STATE = 9;
   localparam int CS_ENABLE   = 16;
   localparam int CS_AUTO     = 17;
   localparam int CS_LINK     = 18;
   localparam int CS_MASK     = 19;

   localparam int TMR_LS_LSB  = 16;
endpackage

// File: rtl/eee_lpi_cnt.sv
`timescale 1ns/1ps
module eee_lpi_cnt #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         tick_i,
   input  logic [W-1:0] limit_i,
   output logic         done_o
);
   localparam logic [W-1:0] CNT_MAX = '1;

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (tick_i && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done_o = (cnt_q >= limit_i);
endmodule

// File: rtl/eee_lpi_rxmon.sv
`timescale 1ns/1ps
module eee_lpi_rxmon #(
   parameter int SYNC = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rx_lpi_i,
   output logic rx_level_o,
   output logic rx_rise_o,
   output logic rx_fall_o
);
   logic [SYNC-1:0] sync_q;
   logic            prev_q;

   generate
      if (SYNC == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q <= '0;
            else         sync_q <= rx_lpi_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q <= '0;
            else         sync_q <= {sync_q[SYNC-2:0], rx_lpi_i};
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= sync_q[SYNC-1];
   end

   assign rx_level_o = sync_q[SYNC-1];
   assign rx_rise_o  =  sync_q[SYNC-1] & ~prev_q;
   assign rx_fall_o  = ~sync_q[SYNC-1] &  prev_q;
endmodule

// File: rtl/eee_lpi_txfsm.sv
`timescale 1ns/1ps
module eee_lpi_txfsm
   import eee_lpi_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       enable_i,
   input  logic       automate_i,
   input  logic       link_up_i,
   input  logic       ls_ok_i,
   input  logic       tx_idle_i,
   input  logic       tx_pend_i,
   input  logic       wake_done_i,
   output lpi_state_e state_o,
   output logic       ev_enter_o,
   output logic       ev_exit_o
);
   lpi_state_e state_q, state_d;
   logic       armed;

   assign armed = enable_i | automate_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LPI_ACTIVE: begin
            if (armed && ls_ok_i && tx_idle_i && !tx_pend_i) state_d = LPI_SLEEP;
         end
         LPI_SLEEP: begin
            if (!link_up_i)                            state_d = LPI_ACTIVE;
            else if (!armed || (automate_i && tx_pend_i)) state_d = LPI_WAKE;
         end
         LPI_WAKE: begin
            if (!link_up_i || wake_done_i) state_d = LPI_ACTIVE;
         end
         default: state_d = LPI_ACTIVE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= LPI_ACTIVE;
      else         state_q <= state_d;
   end

   assign state_o    = state_q;
   assign ev_enter_o = (state_q != LPI_SLEEP) && (state_d == LPI_SLEEP);
   assign ev_exit_o  = (state_q == LPI_SLEEP) && (state_d != LPI_SLEEP);
endmodule

// File: rtl/eee_lpi_regs.sv
`timescale 1ns/1ps
module eee_lpi_regs
   import eee_lpi_pkg::*;
#(
   parameter int WAKE_W   = 16,
   parameter int LS_W     = 11,
   parameter int RST_WAKE = 0,
   parameter int RST_LS   = 0
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_i,
   input  logic                 rd_i,
   input  logic                 addr_i,
   input  logic [REG_W-1:0]     wdata_i,
   output logic [REG_W-1:0]     rdata_o,
   input  logic [NUM_FLAGS-1:0] events_i,
   input  logic                 tx_in_lpi_i,
   input  logic                 rx_in_lpi_i,
   output logic                 enable_o,
   output logic                 automate_o,
   output logic                 link_up_o,
   output logic [WAKE_W-1:0]    wake_time_o,
   output logic [LS_W-1:0]      ls_time_o,
   output logic [NUM_FLAGS-1:0] flags_o,
   output logic                 irq_o
);
   localparam logic [WAKE_W-1:0] WAKE_INIT = WAKE_W'(RST_WAKE);
   localparam logic [LS_W-1:0]   LS_INIT   = LS_W'(RST_LS);

   logic                 mask_q;
   logic [NUM_FLAGS-1:0] flags_q;
   logic                 wr_cs, wr_tmr, rd_clr;

   assign wr_cs  = wr_i & ~addr_i;
   assign wr_tmr = wr_i &  addr_i;
   assign rd_clr = rd_i & ~addr_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         enable_o   <= 1'b0;
         automate_o <= 1'b0;
         link_up_o  <= 1'b0;
         mask_q     <= 1'b0;
      end else if (wr_cs) begin
         enable_o   <= wdata_i[CS_ENABLE];
         automate_o <= wdata_i[CS_AUTO];
         link_up_o  <= wdata_i[CS_LINK];
         mask_q     <= wdata_i[CS_MASK];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wake_time_o <= WAKE_INIT;
         ls_time_o   <= LS_INIT;
      end else if (wr_tmr) begin
         wake_time_o <= wdata_i[WAKE_W-1:0];
         ls_time_o   <= wdata_i[TMR_LS_LSB +: LS_W];
      end
   end

   // new events win over a clearing read in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q <= '0;
      else         flags_q <= (rd_clr ? '0 : flags_q) | events_i;
   end

   always_comb begin
      rdata_o = '0;
      if (!addr_i) begin
         rdata_o[NUM_FLAGS-1:0] = flags_q;
         rdata_o[CS_TX_STATE]   = tx_in_lpi_i;
         rdata_o[CS_RX_STATE]   = rx_in_lpi_i;
         rdata_o[CS_ENABLE]     = enable_o;
         rdata_o[CS_AUTO]       = automate_o;
         rdata_o[CS_LINK]       = link_up_o;
         rdata_o[CS_MASK]       = mask_q;
      end else begin
         rdata_o[WAKE_W-1:0]          = wake_time_o;
         rdata_o[TMR_LS_LSB +: LS_W]  = ls_time_o;
      end
   end

   assign flags_o = flags_q;
   assign irq_o   = (|flags_q) & ~mask_q;
endmodule

// File: rtl/eee_lpi_ctrl.sv
`timescale 1ns/1ps
module eee_lpi_ctrl
   import eee_lpi_pkg::*;
#(
   parameter int WAKE_W   = 16,
   parameter int LS_W     = 11,
   parameter int RX_SYNC  = 2,
   parameter int RST_WAKE = 0,
   parameter int RST_LS   = 0
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        reg_wr_i,
   input  logic        reg_rd_i,
   input  logic        reg_addr_i,
   input  logic [31:0] reg_wdata_i,
   output logic [31:0] reg_rdata_o,
   input  logic        tx_idle_i,
   input  logic        tx_pend_i,
   input  logic        rx_lpi_i,
   input  logic        us_tick_i,
   input  logic        ms_tick_i,
   output logic        tx_lpi_o,
   output logic        tx_hold_o,
   output logic        irq_o
);
   if (WAKE_W < 1 || WAKE_W > TMR_LS_LSB) begin : g_bad_wake_w
      $error("WAKE_W must lie in 1..%0d", TMR_LS_LSB);
   end
   if (LS_W < 1 || TMR_LS_LSB + LS_W > REG_W) begin : g_bad_ls_w
      $error("LS_W does not fit the timer word");
   end
   if (RX_SYNC < 1) begin : g_bad_sync
      $error("RX_SYNC must be at least 1");
   end
   if (RST_WAKE < 0 || RST_WAKE >= (1 << WAKE_W)) begin : g_bad_rst_wake
      $error("RST_WAKE does not fit WAKE_W");
   end
   if (RST_LS < 0 || RST_LS >= (1 << LS_W)) begin : g_bad_rst_ls
      $error("RST_LS does not fit LS_W");
   end

   logic                 enable, automate, link_up;
   logic [WAKE_W-1:0]    wake_time;
   logic [LS_W-1:0]      ls_time;
   logic [NUM_FLAGS-1:0] flags, events;
   logic                 ls_done, ls_ok, wake_done;
   logic                 rx_level, rx_rise, rx_fall;
   logic                 ev_enter, ev_exit;
   lpi_state_e           fsm_state;

   eee_lpi_regs #(
      .WAKE_W  (WAKE_W),
      .LS_W    (LS_W),
      .RST_WAKE(RST_WAKE),
      .RST_LS  (RST_LS)
   ) regs_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (reg_wr_i),
      .rd_i       (reg_rd_i),
      .addr_i     (reg_addr_i),
      .wdata_i    (reg_wdata_i),
      .rdata_o    (reg_rdata_o),
      .events_i   (events),
      .tx_in_lpi_i(fsm_state == LPI_SLEEP),
      .rx_in_lpi_i(rx_level),
      .enable_o   (enable),
      .automate_o (automate),
      .link_up_o  (link_up),
      .wake_time_o(wake_time),
      .ls_time_o  (ls_time),
      .flags_o    (flags),
      .irq_o      (irq_o)
   );

   // link-stable count restarts whenever the host reports link down
   eee_lpi_cnt #(.W(LS_W)) ls_cnt_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (~link_up),
      .tick_i (ms_tick_i),
      .limit_i(ls_time),
      .done_o (ls_done)
   );
   assign ls_ok = link_up & ls_done;

   eee_lpi_cnt #(.W(WAKE_W)) wake_cnt_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (fsm_state != LPI_WAKE),
      .tick_i (us_tick_i),
      .limit_i(wake_time),
      .done_o (wake_done)
   );

   eee_lpi_txfsm fsm_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .enable_i   (enable),
      .automate_i (automate),
      .link_up_i  (link_up),
      .ls_ok_i    (ls_ok),
      .tx_idle_i  (tx_idle_i),
      .tx_pend_i  (tx_pend_i),
      .wake_done_i(wake_done),
      .state_o    (fsm_state),
      .ev_enter_o (ev_enter),
      .ev_exit_o  (ev_exit)
   );

   eee_lpi_rxmon #(.SYNC(RX_SYNC)) rxmon_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rx_lpi_i  (rx_lpi_i),
      .rx_level_o(rx_level),
      .rx_rise_o (rx_rise),
      .rx_fall_o (rx_fall)
   );

   always_comb begin
      events             = '0;
      events[FLG_TX_IN]  = ev_enter;
      events[FLG_TX_OUT] = ev_exit;
      events[FLG_RX_IN]  = rx_rise;
      events[FLG_RX_OUT] = rx_fall;
   end

   assign tx_lpi_o  = (fsm_state == LPI_SLEEP);
   assign tx_hold_o = (fsm_state != LPI_ACTIVE);
endmodule

// File: rtl/eee_lpi_chk.sv
`timescale 1ns/1ps
module eee_lpi_chk
   import eee_lpi_pkg::*;
(
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 reg_rd_i,
   input logic                 reg_addr_i,
   input logic                 tx_idle_i,
   input logic                 tx_pend_i,
   input logic                 tx_lpi_o,
   input logic                 tx_hold_o,
   input logic                 irq_o,
   input lpi_state_e           state,
   input logic                 enable,
   input logic                 automate,
   input logic                 link_up,
   input logic [NUM_FLAGS-1:0] flags,
   input logic [NUM_FLAGS-1:0] events
);
   assert_entry_when_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tx_lpi_o) |-> $past(tx_idle_i && !tx_pend_i));

   assert_hold_in_lpi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_lpi_o |-> tx_hold_o);

   assert_auto_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == LPI_SLEEP && automate && tx_pend_i && link_up) |=> (!tx_lpi_o && tx_hold_o));

   assert_host_stays_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == LPI_SLEEP && enable && !automate && link_up) |=> tx_lpi_o);

   assert_link_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state != LPI_ACTIVE && !link_up) |=> (!tx_lpi_o && !tx_hold_o));

   assert_exit_flagged_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(tx_lpi_o) |-> flags[FLG_TX_OUT]);

   assert_read_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_rd_i && !reg_addr_i && events == '0) |=> (flags == '0));

   assert_irq_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags == '0) |-> !irq_o);
endmodule

bind eee_lpi_ctrl eee_lpi_chk chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .reg_rd_i  (reg_rd_i),
   .reg_addr_i(reg_addr_i),
   .tx_idle_i (tx_idle_i),
   .tx_pend_i (tx_pend_i),
   .tx_lpi_o  (tx_lpi_o),
   .tx_hold_o (tx_hold_o),
   .irq_o     (irq_o),
   .state     (fsm_state),
   .enable    (enable),
   .automate  (automate),
   .link_up   (link_up),
   .flags     (flags),
   .events    (events)
);

// File: tb/eee_lpi_ctrl_tb_top.sv
`timescale 1ns/1ps
module eee_lpi_ctrl_tb_top;
   localparam int SYNC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
   logic [31:0] wdata = '0, rdata;
   logic        tx_idle = 1'b1, tx_pend = 1'b0, rx_lpi = 1'b0;
   logic        us_tick = 1'b0, ms_tick = 1'b0;
   logic        tx_lpi, tx_hold, irq;
   int          n_chk = 0, n_fail = 0;
   logic [31:0] v;

   always #2.5 clk = ~clk;

   eee_lpi_ctrl #(.WAKE_W(16), .LS_W(11), .RX_SYNC(SYNC), .RST_WAKE(5), .RST_LS(2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr_en), .reg_rd_i(rd_en), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tx_idle_i(tx_idle), .tx_pend_i(tx_pend),
      .rx_lpi_i(rx_lpi), .us_tick_i(us_tick), .ms_tick_i(ms_tick),
      .tx_lpi_o(tx_lpi), .tx_hold_o(tx_hold), .irq_o(irq));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(int n = 1);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wr(logic a, logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd(logic a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      step();
      rd_en = 1'b0;
   endtask

   task automatic ms_pulse(); ms_tick = 1'b1; step(); ms_tick = 1'b0; endtask
   task automatic us_pulse(); us_tick = 1'b1; step(); us_tick = 1'b0; endtask

   function automatic logic [31:0] ctl(bit en, bit au, bit lk, bit mk);
      return (32'(en) << 16) | (32'(au) << 17) | (32'(lk) << 18) | (32'(mk) << 19);
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step();
      // R1 reset state
      check("R1 tx_lpi", 32'(tx_lpi), 0);
      check("R1 tx_hold", 32'(tx_hold), 0);
      check("R1 irq", 32'(irq), 0);
      rd(1'b0, v); check("R1 ctrl word", v, 0);
      rd(1'b1, v); check("R1 timer word", v, 32'h0002_0005);

      // R2 timer layout
      wr(1'b1, 32'hFFFF_FFFF); rd(1'b1, v); check("R2 all ones", v, 32'h07FF_FFFF);
      wr(1'b1, 32'h0123_4567); rd(1'b1, v); check("R2 pattern", v, 32'h0123_4567);

      // R3 R5 R8 R11 sweep of link-stable and wake times
      for (int L = 0; L < 4; L++) begin
         for (int W = 0; W < 5; W++) begin
            tx_idle = 1'b1; tx_pend = 1'b0;
            wr(1'b1, 32'(W) | (32'(L) << 16));
            wr(1'b0, ctl(1, 1, 1, 0));
            for (int i = 0; i < L; i++) begin
               check("R3 wait link-stable", 32'(tx_lpi), 0);
               ms_pulse();
            end
            check("R3 not yet", 32'(tx_lpi), 0);
            step();
            check("R3 entered", {30'd0, tx_lpi, tx_hold}, 32'h3);
            check("R11 irq on entry", 32'(irq), 1);
            rd(1'b0, v);
            check("R8 entry flag", v, 32'h1 | 32'h100 | ctl(1, 1, 1, 0));
            check("R11 irq after clear", 32'(irq), 0);
            tx_pend = 1'b1;
            step();
            check("R5 lpi dropped", {30'd0, tx_lpi, tx_hold}, 32'h1);
            for (int i = 0; i < W; i++) begin
               us_pulse();
               check("R5 hold during wake", 32'(tx_hold), 1);
            end
            step();
            check("R5 hold released", 32'(tx_hold), 0);
            wr(1'b0, 32'h0);
            tx_pend = 1'b0;
            rd(1'b0, v);
            check("R8 exit flag", v, 32'h2);
         end
      end

      // R4 no entry while busy or pending
      wr(1'b1, 32'h0000_0004);
      tx_idle = 1'b0;
      wr(1'b0, ctl(1, 1, 1, 0));
      step(5); check("R4 busy", 32'(tx_lpi), 0);
      tx_idle = 1'b1; tx_pend = 1'b1;
      step(5); check("R4 pending", 32'(tx_lpi), 0);
      tx_pend = 1'b0;
      step(); check("R4 enter when clear", 32'(tx_lpi), 1);

      // R7 link drop: immediate exit, then restart of link-stable count
      wr(1'b1, 32'h0002_0004);
      wr(1'b0, ctl(1, 1, 0, 0));
      check("R7 still lpi at write edge", 32'(tx_lpi), 1);
      step();
      check("R7 immediate exit", {30'd0, tx_lpi, tx_hold}, 32'h0);
      wr(1'b0, ctl(1, 1, 1, 0));
      step(3); check("R7 restart needs ticks", 32'(tx_lpi), 0);
      ms_pulse(); step(); check("R7 one tick short", 32'(tx_lpi), 0);
      ms_pulse(); step(); check("R7 re-entered", 32'(tx_lpi), 1);
      wr(1'b0, ctl(1, 1, 0, 0));
      step();
      rd(1'b0, v);

      // R6 host-directed mode
      wr(1'b1, 32'h0000_0002);
      wr(1'b0, ctl(1, 0, 1, 0));
      step(); check("R6 host entry", 32'(tx_lpi), 1);
      tx_pend = 1'b1;
      step(5); check("R6 pending ignored", {30'd0, tx_lpi, tx_hold}, 32'h3);
      wr(1'b0, ctl(0, 0, 1, 0));
      check("R6 lpi at write edge", 32'(tx_lpi), 1);
      step(); check("R6 wake", {30'd0, tx_lpi, tx_hold}, 32'h1);
      us_pulse(); check("R6 hold tick1", 32'(tx_hold), 1);
      us_pulse(); check("R6 hold tick2", 32'(tx_hold), 1);
      step(); check("R6 released", 32'(tx_hold), 0);
      tx_pend = 1'b0;
      wr(1'b0, 32'h0);
      rd(1'b0, v);
      check("R8 host flags", v, 32'h3);

      // R9 R10 receive edges, read coinciding with event
      rx_lpi = 1'b1;
      step(SYNC);
      rd(1'b0, v); check("R9 rx level, flag not yet", v & 32'h30F, 32'h200);
      rd(1'b0, v); check("R10 event kept over read", v & 32'h30F, 32'h204);
      rd(1'b0, v); check("R10 cleared", v & 32'h30F, 32'h200);
      rx_lpi = 1'b0;
      step(SYNC + 2);
      rd(1'b0, v); check("R9 rx exit flag", v & 32'h30F, 32'h008);

      // R11 mask, R10 timer read does not clear
      rx_lpi = 1'b1;
      step(SYNC + 2);
      check("R11 irq set", 32'(irq), 1);
      wr(1'b0, ctl(0, 0, 0, 1));
      check("R11 masked", 32'(irq), 0);
      wr(1'b0, ctl(0, 0, 0, 0));
      check("R11 unmasked", 32'(irq), 1);
      rd(1'b1, v);
      check("R10 timer read keeps irq", 32'(irq), 1);
      rd(1'b0, v); check("R10 flag kept", v & 32'hF, 32'h4);
      check("R10 irq after status read", 32'(irq), 0);

      summary();
      $finish;
   end
endmodule